// File: doc/BRIEF.md
# Cascadable Pipelined Phase Accumulator

This block keeps a running 32-bit phase and adds a phase increment to it on every rising clock edge, wrapping modulo 2^32. The synthesized frequency is the clock frequency times the increment divided by 2^32. A carry input adds one more count to the increment. A carry output marks each wraparound. Together they let two units be chained into a 64-bit accumulator: the lower unit's carry output drives the upper unit's carry input.

To reach high clock rates, the 32-bit add is split into byte-wide slices, and each slice registers its carry into the next one. The increment bytes are delayed on the way in so that each slice sees the byte that belongs to its sample. The sum bytes are delayed on the way out so that the whole phase word appears in one cycle. The accumulator takes a new increment every cycle and never stalls. A change of increment never disturbs the phase already reached, so frequency changes are phase-continuous.

Top module: `cascade_phase_acc`

## Requirements
- R1: For the increment and carry input sampled at rising edge n, `phase_o` holds the running sum of all (increment + carry input) sampled since reset, up to and including edge n. The sum is taken modulo 2^32 and is visible just after edge n+3, that is, NUM_SLICES-1 edges later.
- R2: A carry input of 1 raises the effective increment of that sample by exactly one. An increment of 0 with a carry input of 1 steps the phase by 1. An increment of 32'hFFFF_FFFF with a carry input of 1 leaves the phase unchanged.
- R3: `carry_out_o` is 1 in exactly the cycles whose `phase_o` result came from a sum that overflowed 32 bits, and 0 in every other cycle. This includes a carry that ripples through all four byte slices, for example 32'hFFFF_FFFF + 1.
- R4: A synchronous reset sampled high forces `phase_o` to 0 and `carry_out_o` to 0 after that edge.
- R5: After reset is released, `phase_o` and `carry_out_o` stay 0 for the first three edges. The first nonzero result is the increment sampled at the first edge with reset low, so accumulation starts from zero phase.
- R6: The increment may change on every cycle with no stall. Each change continues from the phase already reached and never resets it.
- R7: In a 64-bit cascade, the upper unit's carry input is driven by the lower unit's carry output, and the upper unit leaves reset NUM_SLICES edges after the lower unit. With that wiring, {upper `phase_o`, lower `phase_o` from NUM_SLICES cycles earlier} equals the 64-bit running sum of {upper increment, lower increment}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| incr_i | input | 32 | Phase increment added each cycle |
| carry_in_i | input | 1 | Adds one to this cycle's increment; tie to 0 when used alone |
| phase_o | output | 32 | Accumulated phase, three cycles behind its inputs |
| carry_out_o | output | 1 | High for the one result cycle whose sum wrapped |

## Verification
Every increment sampled at edge n has its phase and carry result due just after edge n+3. The scoreboard therefore holds each expected item until three later items are queued, then compares it at the falling edge. During the three edges after a reset release, the outputs must read zero. In the cascade test, each 64-bit result is due seven edges after its lower sample: four edges of reset stagger plus three of pipeline. It is compared against the lower phase kept from four cycles earlier.

// File: rtl/phacc_pkg.sv
package phacc_pkg;
    // Default slicing of the accumulator: four byte-wide adder stages.
    parameter int unsigned PHACC_SLICE_W_DEF = 8;
    parameter int unsigned PHACC_SLICES_DEF  = 4;

    // Bit position of the lowest bit of slice k.
    function automatic int unsigned slice_lsb(input int unsigned k, input int unsigned w);
        return k * w;
    endfunction
endpackage

// File: rtl/phacc_delay.sv
// Fixed-depth register delay line; depth 0 is a plain wire.
module phacc_delay #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q_o = d_i;
        end else begin : g_regs
            logic [W-1:0] pipe_d [DEPTH];
            logic [W-1:0] pipe_q [DEPTH];

            always_comb begin
                pipe_d[0] = d_i;
                for (int i = 1; i < int'(DEPTH); i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < int'(DEPTH); i++) begin
                        pipe_q[i] <= '0;
                    end
                end else begin
                    for (int i = 0; i < int'(DEPTH); i++) begin
                        pipe_q[i] <= pipe_d[i];
                    end
                end
            end

            assign q_o = pipe_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/phacc_slice.sv
// One slice of the accumulator: holds its own slice of the running phase
// and registers the carry handed to the next slice.
module phacc_slice #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] addend_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    typedef struct packed {
        logic [W-1:0] sum;
        logic         cy;
    } slice_st_t;

    slice_st_t    st_d;
    slice_st_t    st_q;
    logic [W:0]   wide_sum;

    always_comb begin
        wide_sum = {1'b0, st_q.sum} + {1'b0, addend_i} + {{W{1'b0}}, cin_i};
        st_d.sum = wide_sum[W-1:0];
        st_d.cy  = wide_sum[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_o  = st_q.sum;
    assign cout_o = st_q.cy;
endmodule

// File: rtl/cascade_phase_acc.sv
module cascade_phase_acc
    import phacc_pkg::*;
#(
    parameter  int unsigned SLICE_W    = PHACC_SLICE_W_DEF,
    parameter  int unsigned NUM_SLICES = PHACC_SLICES_DEF,
    localparam int unsigned ACC_W      = SLICE_W * NUM_SLICES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] incr_i,
    input  logic             carry_in_i,
    output logic [ACC_W-1:0] phase_o,
    output logic             carry_out_o
);
    localparam int unsigned LATENCY = NUM_SLICES - 1;

    logic [SLICE_W-1:0] addend  [NUM_SLICES];
    logic [SLICE_W-1:0] sl_sum  [NUM_SLICES];
    logic [NUM_SLICES:0] cy_chain;

    assign cy_chain[0] = carry_in_i;

    generate
        for (genvar k = 0; k < int'(NUM_SLICES); k++) begin : g_slice
            localparam int unsigned LSB = slice_lsb(k, SLICE_W);

            // Input skew: slice k works on the sample taken k edges ago.
            phacc_delay #(.W(SLICE_W), .DEPTH(k)) u_skew (
                .clk (clk),
                .rst (rst),
                .d_i (incr_i[LSB +: SLICE_W]),
                .q_o (addend[k])
            );

            phacc_slice #(.W(SLICE_W)) u_add (
                .clk      (clk),
                .rst      (rst),
                .addend_i (addend[k]),
                .cin_i    (cy_chain[k]),
                .sum_o    (sl_sum[k]),
                .cout_o   (cy_chain[k+1])
            );

            // Output deskew: align every slice with the top slice.
            phacc_delay #(.W(SLICE_W), .DEPTH(LATENCY - k)) u_deskew (
                .clk (clk),
                .rst (rst),
                .d_i (sl_sum[k]),
                .q_o (phase_o[LSB +: SLICE_W])
            );
        end
    endgenerate

    // The top slice's carry is already aligned with the deskewed word.
    assign carry_out_o = cy_chain[NUM_SLICES];
endmodule

module cascade_phase_acc_chk #(
    parameter int unsigned SLICE_W    = 8,
    parameter int unsigned NUM_SLICES = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic [SLICE_W*NUM_SLICES-1:0] phase_o,
    input logic                          carry_out_o
);
    // R4
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (phase_o == '0) && !carry_out_o);

    // R5
    fill_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !rst) |=> (phase_o == '0) && !carry_out_o);

    // R3
    wrap_carry_chk: assert property (@(posedge clk) disable iff (rst)
        carry_out_o |-> (phase_o <= $past(phase_o)));

    // R1
    no_wrap_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !carry_out_o |-> (phase_o >= $past(phase_o)));
endmodule

bind cascade_phase_acc cascade_phase_acc_chk #(
    .SLICE_W    (SLICE_W),
    .NUM_SLICES (NUM_SLICES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_o     (phase_o),
    .carry_out_o (carry_out_o)
);

// File: tb/sim_cascade_phase_acc.sv
`timescale 1ns/1ps
module sim_cascade_phase_acc;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst0 = 1'b1;
    logic        rst1 = 1'b1;
    logic        cin0 = 1'b0;
    logic [31:0] inc0 = '0;
    logic [31:0] inc1 = '0;
    logic [31:0] phase0, phase1;
    logic        cout0, cout1;

    always #2.5 clk = ~clk;

    cascade_phase_acc u0 (
        .clk(clk), .rst(rst0), .incr_i(inc0), .carry_in_i(cin0),
        .phase_o(phase0), .carry_out_o(cout0)
    );

    cascade_phase_acc u1 (
        .clk(clk), .rst(rst1), .incr_i(inc1), .carry_in_i(cout0),
        .phase_o(phase1), .carry_out_o(cout1)
    );

    typedef struct {
        logic [31:0] ph;
        logic        cy;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] exp64_q[$];
    logic [31:0] lo_hist[$];
    exp_t        e_cur;
    logic [63:0] e64;
    logic [31:0] m_acc = '0;
    logic [63:0] m64 = '0;
    int          n_smp = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          casc = 1'b0;
    string       cur_tag = "R1";
    logic        rst_s = 1'b1;

    always @(posedge clk) rst_s <= rst0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one sample per call, expected result queued at the sampling edge.
    task automatic apply(input logic [31:0] inc, input logic cin);
        logic [32:0] s;
        @(negedge clk);
        rst0 = 1'b0;
        inc0 = inc;
        cin0 = cin;
        if (casc && n_smp == LAT + 1) rst1 = 1'b0;
        @(posedge clk);
        s = {1'b0, m_acc} + {1'b0, inc} + 33'(cin);
        m_acc = s[31:0];
        exp_q.push_back('{s[31:0], s[32], s[32] ? "R3" : cur_tag});
        m64 = m64 + {inc1, inc} + 64'(cin);
        exp64_q.push_back(m64);
        n_smp++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst0 = 1'b1;
        rst1 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        m_acc = '0;
        m64   = '0;
        n_smp = 0;
        exp_q.delete();
        exp64_q.delete();
        lo_hist.delete();
        // R4: cleared right after the reset edge
        check(phase0 == '0 && cout0 == 1'b0, "R4",
              {31'd0, cout0, phase0}, 64'd0);
    endtask

    // Monitor: each result is due LAT edges after its sample.
    always @(negedge clk) begin
        if (!rst_s) begin
            if (exp_q.size() > LAT) begin
                e_cur = exp_q.pop_front();
                check(phase0 == e_cur.ph && cout0 == e_cur.cy, e_cur.tag,
                      {31'd0, cout0, phase0}, {31'd0, e_cur.cy, e_cur.ph});
            end else begin
                // R5: pipeline fill after reset reads as zero phase
                check(phase0 == '0 && cout0 == 1'b0, "R5",
                      {31'd0, cout0, phase0}, 64'd0);
            end
            if (casc) begin
                lo_hist.push_back(phase0);
                if (lo_hist.size() > LAT + 2) void'(lo_hist.pop_front());
                if (exp64_q.size() > 2 * LAT + 1) begin
                    e64 = exp64_q.pop_front();
                    // R7: upper phase joined with lower phase LAT+1 cycles older
                    check({phase1, lo_hist[0]} == e64, "R7", {phase1, lo_hist[0]}, e64);
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        n_bad++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        do_reset();

        // R1: steady increment, several wraps (wrap items are tagged R3)
        cur_tag = "R1";
        for (int i = 0; i < 24; i++) apply(32'h1234_5679, 1'b0);

        // R2: carry input alone steps by one; all-ones plus carry keeps phase
        cur_tag = "R2";
        for (int i = 0; i < 6; i++) apply(32'h0000_0000, 1'b1);
        for (int i = 0; i < 4; i++) apply(32'hFFFF_FFFF, 1'b1);

        // R6: increment changes every cycle, phase continues
        cur_tag = "R6";
        for (int i = 0; i < 20; i++) begin
            logic [7:0] b;
            b = 8'(i * 37);
            apply({b, 8'hA5, ~b, 8'h3C}, i[0]);
        end

        // R3: carry rippling through every byte slice
        do_reset();
        cur_tag = "R3";
        apply(32'hFFFF_FFFF, 1'b0);
        apply(32'h0000_0001, 1'b0);
        apply(32'h0000_0000, 1'b0);
        apply(32'hFFFF_FF00, 1'b0);
        apply(32'h0000_0100, 1'b0);

        // R5: mid-run reset, accumulation restarts from zero
        do_reset();
        cur_tag = "R5";
        for (int i = 0; i < 8; i++) apply(32'h4000_0000, 1'b0);

        // R7: two units cascaded into 64 bits
        inc1 = 32'h0000_0003;
        do_reset();
        casc = 1'b1;
        cur_tag = "R7";
        for (int i = 0; i < 40; i++) apply(32'hC000_0001, 1'b0);
        casc = 1'b0;
        cur_tag = "R1";
        for (int i = 0; i < LAT + 1; i++) apply(32'h0000_0000, 1'b0);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule